// File: doc/BRIEF.md
# Dual-Row Differential Time Quantizer

This block is the digital side of a column time-to-digital stage that serves two image rows read out together. Each row has an active-low flip input that falls when that row's comparator trips during the ramp. Within one coarse window the block works out which row tripped first. The earlier row is measured from its trip to the end of the window. The later row is measured only over the gap between the two trips. Rows that are close in value then produce short codes, so fewer capture bits toggle. The fast clock stands in for the fine delay taps. Each window holds exactly `2**RES_BITS` fast ticks, and each tick is one tap.

A window opens in the cycle after `clear_i` is pulsed. Tick phase 0 is that first cycle. The window closes after phase `2**RES_BITS-1`. One cycle after it closes, the block pulses `done_o` and presents two latched thermometer codes and a row-order flag. These stay unchanged until the next `done_o`. A live arbitration output shows the running decision: high means the odd row is assumed first.

Top module: `dual_row_tdq`

## Requirements
- R1: After reset, `arb_o`=1, `order_o`=0, `done_o`=0, and both codes are zero.
- R2: If the odd row trips first, at phase p, then `odd_code_o` holds TAPS-p ones. If the even row trips at a later phase q in the window, `even_code_o` holds q-p ones. `order_o` is 0.
- R3: If the even row trips first, `arb_o` goes low in the cycle after the trip. At `done_o`, `order_o` is 1, `even_code_o` holds the full count (TAPS-p), and `odd_code_o` holds the gap.
- R4: Once a first trip is seen in a window, a later trip of the other row does not change `arb_o` or the latched order.
- R5: If both rows trip on the same tick, the odd row is treated as first and the gap code is all zeros.
- R6: If the later row does not trip inside the window, its code is all ones (TAPS ones).
- R7: If neither row trips inside the window, both codes are zero and `order_o` is 0.
- R8: `done_o` is a single-cycle pulse, raised in the cycle after the last window tick. The codes and `order_o` change only when `done_o` is raised.
- R9: Each code is a thermometer code. Bit 0 is the first tap, ones fill the low bits, and zeros fill the rest.
- R10: Flip inputs that are asserted after the window has closed and before the next clear have no effect on `arb_o`, `done_o`, or the latched outputs.
- R11: The cycle right after `clear_i` is tick phase 0 of a new window, and arbitration is reset to odd-first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast tick clock (one tap per cycle) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Starts a new window and clears arbitration |
| flip_odd_ni | input | 1 | Odd-row comparator trip, active low |
| flip_even_ni | input | 1 | Even-row comparator trip, active low |
| arb_o | output | 1 | Live arbitration, high while odd row is taken as first |
| order_o | output | 1 | Latched order flag, 1 when even row was first |
| done_o | output | 1 | One-cycle pulse when codes are valid |
| odd_code_o | output | 2**RES_BITS | Odd-row thermometer code |
| even_code_o | output | 2**RES_BITS | Even-row thermometer code |

## Verification
The trip-phase pairs cover both row orders, with gaps of zero, one and several taps. This separates a swapped full/gap assignment from a wrong gap length. Trips at phase 0 and at the last phase probe the ends of the full-count range. A window where only one row trips checks the all-ones saturation of the missing stop. A window where neither row trips, followed by trips after the window has closed, shows that arbitration ignores events outside the window. The live arbitration output is compared every cycle, so a late trip that flips it is caught at once.

// File: rtl/tdq_pkg.sv
package tdq_pkg;
  typedef enum logic {ROW_ODD = 1'b0, ROW_EVEN = 1'b1} row_e;
endpackage

// File: rtl/tdq_arbiter.sv
module tdq_arbiter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic win_i,
  input  logic flip_odd_ni,
  input  logic flip_even_ni,
  output logic arb_o,
  output logic arb_d_o,
  output logic started_o,
  output logic both_o
);
  logic odd_seen_q, even_seen_q, arb_q;
  logic odd_now, even_now, any_seen;

  assign odd_now   = win_i & ~flip_odd_ni;
  assign even_now  = win_i & ~flip_even_ni;
  assign any_seen  = odd_seen_q | even_seen_q;
  assign started_o = any_seen | odd_now | even_now;
  assign both_o    = (odd_seen_q | odd_now) & (even_seen_q | even_now);
  // even wins only if nothing seen yet and odd not on the same tick
  assign arb_d_o   = (!any_seen && even_now && !odd_now) ? 1'b0 : arb_q;
  assign arb_o     = arb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_seen_q  <= 1'b0;
      even_seen_q <= 1'b0;
      arb_q       <= 1'b1;
    end else if (clear_i) begin
      odd_seen_q  <= 1'b0;
      even_seen_q <= 1'b0;
      arb_q       <= 1'b1;
    end else begin
      odd_seen_q  <= odd_seen_q | odd_now;
      even_seen_q <= even_seen_q | even_now;
      arb_q       <= arb_d_o;
    end
  end

  // R4
  arb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arb_q && !clear_i) |=> !arb_q);
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_i && !clear_i) |=> $stable(arb_q));
endmodule

// File: rtl/tdq_sat_cnt.sv
module tdq_sat_cnt #(
  parameter int W   = 4,
  parameter int MAX = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] nx_o
);
  logic [W-1:0] q;

  assign nx_o = (inc_i && q < W'(MAX)) ? q + 1'b1 : q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (clr_i) q <= '0;
    else            q <= nx_o;
  end

  // R9
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q <= W'(MAX));
endmodule

// File: rtl/tdq_therm.sv
module tdq_therm #(
  parameter int W    = 4,
  parameter int TAPS = 8
) (
  input  logic [W-1:0]    cnt_i,
  output logic [TAPS-1:0] code_o
);
  for (genvar i = 0; i < TAPS; i++) begin : g_bit
    assign code_o[i] = (cnt_i > W'(i));
  end
endmodule

// File: rtl/dual_row_tdq.sv
module dual_row_tdq
  import tdq_pkg::*;
#(
  parameter int RES_BITS = 3,
  localparam int TAPS    = 2 ** RES_BITS,
  localparam int CW      = RES_BITS + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            flip_odd_ni,
  input  logic            flip_even_ni,
  output logic            arb_o,
  output logic            order_o,
  output logic            done_o,
  output logic [TAPS-1:0] odd_code_o,
  output logic [TAPS-1:0] even_code_o
);
  logic                win_q, done_q;
  logic [RES_BITS-1:0] ph_q;
  logic                edge_w, arb_d, started, both;
  logic [CW-1:0]       full_nx, gap_nx, gap_cnt;
  logic [TAPS-1:0]     full_code, gap_code, odd_q, even_q;
  row_e                order_q;

  assign edge_w = win_q && (ph_q == RES_BITS'(TAPS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= 1'b0;
      ph_q  <= '0;
    end else if (clear_i) begin
      win_q <= 1'b1;
      ph_q  <= '0;
    end else if (edge_w) begin
      win_q <= 1'b0;
    end else if (win_q) begin
      ph_q  <= ph_q + 1'b1;
    end
  end

  tdq_arbiter u_arb (
    .clk_i, .rst_ni, .clear_i,
    .win_i       (win_q),
    .flip_odd_ni, .flip_even_ni,
    .arb_o,
    .arb_d_o     (arb_d),
    .started_o   (started),
    .both_o      (both)
  );

  tdq_sat_cnt #(.W(CW), .MAX(TAPS)) u_full (
    .clk_i, .rst_ni, .clr_i(clear_i),
    .inc_i(win_q & started), .nx_o(full_nx)
  );

  tdq_sat_cnt #(.W(CW), .MAX(TAPS)) u_gap (
    .clk_i, .rst_ni, .clr_i(clear_i),
    .inc_i(win_q & started & ~both), .nx_o(gap_nx)
  );

  // missing second stop saturates to all ones
  assign gap_cnt = both ? gap_nx : (started ? CW'(TAPS) : '0);

  tdq_therm #(.W(CW), .TAPS(TAPS)) u_th_full (.cnt_i(full_nx), .code_o(full_code));
  tdq_therm #(.W(CW), .TAPS(TAPS)) u_th_gap  (.cnt_i(gap_cnt), .code_o(gap_code));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      order_q <= ROW_ODD;
      odd_q   <= '0;
      even_q  <= '0;
    end else begin
      done_q <= edge_w;
      if (edge_w) begin
        order_q <= arb_d ? ROW_ODD : ROW_EVEN;
        odd_q   <= arb_d ? full_code : gap_code;
        even_q  <= arb_d ? gap_code : full_code;
      end
    end
  end

  assign done_o      = done_q;
  assign order_o     = order_q;
  assign odd_code_o  = odd_q;
  assign even_code_o = even_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_w |=> ($stable(odd_code_o) && $stable(even_code_o) && $stable(order_o)));
  // R9
  therm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (((odd_code_o & (odd_code_o + 1'b1)) == '0) &&
                ((even_code_o & (even_code_o + 1'b1)) == '0)));
  // R3
  order_arb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (order_o != arb_o));
endmodule

// File: tb/dual_row_tdq_tb.sv
module dual_row_tdq_tb;
  localparam int RES_BITS = 3;
  localparam int TAPS = 2 ** RES_BITS;

  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0, fo_n = 1'b1, fe_n = 1'b1;
  logic arb, order, done;
  logic [TAPS-1:0] oc, ec;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dual_row_tdq #(.RES_BITS(RES_BITS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear),
    .flip_odd_ni(fo_n), .flip_even_ni(fe_n),
    .arb_o(arb), .order_o(order), .done_o(done),
    .odd_code_o(oc), .even_code_o(ec)
  );

  function automatic logic [TAPS-1:0] th(int n);
    logic [TAPS-1:0] r = '0;
    for (int i = 0; i < TAPS; i++) if (i < n) r[i] = 1'b1;
    return r;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // phases outside 0..TAPS-1 mean no trip in the window
  task automatic run_period(int po, int pe, string req);
    bit vo = (po >= 0 && po < TAPS), ve = (pe >= 0 && pe < TAPS);
    bit ef = ve && (!vo || pe < po);
    int f = ef ? pe : po;
    bit vs = ef ? vo : ve;
    int s = ef ? po : pe;
    int full_n = (vo || ve) ? TAPS - f : 0;
    int gap_n = (vo || ve) ? (vs ? s - f : TAPS) : 0;
    logic [TAPS-1:0] exp_o = ef ? th(gap_n) : th(full_n);
    logic [TAPS-1:0] exp_e = ef ? th(full_n) : th(gap_n);
    @(negedge clk); clear = 1'b1; fo_n = 1'b1; fe_n = 1'b1;
    @(negedge clk); clear = 1'b0;
    for (int k = 0; k < TAPS; k++) begin
      if (k > 0) begin
        chk(arb == !(ef && pe <= k - 1), {req, " arb"}, arb, !(ef && pe <= k - 1));
        chk(done == 1'b0, "R8 done early", done, 0);
      end else begin
        chk(arb == 1'b1, "R11 arb after clear", arb, 1);
      end
      fo_n = !(po >= 0 && k >= po);
      fe_n = !(pe >= 0 && k >= pe);
      @(negedge clk);
    end
    chk(done == 1'b1, "R8 done", done, 1);
    chk(order == ef, {req, " order"}, order, ef);
    chk(oc == exp_o, {req, " odd code"}, oc, exp_o);
    chk(ec == exp_e, {req, " even code"}, ec, exp_e);
    @(negedge clk);
    chk(done == 1'b0, "R8 single pulse", done, 0);
    chk(oc == exp_o && ec == exp_e, "R8 hold", {oc, ec}, {exp_o, exp_e});
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(arb == 1 && order == 0 && done == 0, "R1 flags", {arb, order, done}, 3'b100);
    chk(oc == '0 && ec == '0, "R1 codes", {oc, ec}, 0);
    run_period(2, 5, "R2");
    run_period(4, 5, "R2");
    run_period(0, 7, "R2");
    run_period(5, 1, "R3");
    run_period(7, 0, "R3");
    run_period(6, 2, "R4");
    run_period(3, 3, "R5");
    run_period(0, 0, "R5");
    run_period(0, -1, "R6");
    run_period(-1, 4, "R6");
    run_period(-1, -1, "R7");
    // R10: trips after the window closed, no clear
    for (int k = 0; k < 4; k++) begin
      fe_n = 1'b0; fo_n = (k < 2);
      @(negedge clk);
      chk(arb == 1'b1, "R10 arb", arb, 1);
      chk(done == 1'b0, "R10 done", done, 0);
      chk(oc == '0 && ec == '0 && order == 0, "R10 outputs", {order, oc, ec}, 0);
    end
    run_period(1, 2, "R11");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule